// File: doc/BRIEF.md
# Eight-bit timer/counter with a shared divide chain

The block is an 8-bit up-counter that advances on the instruction-cycle tick or on edges of an external clock pin. It has a single 8-bit divide chain, and a configuration bit hands that chain to one of two users. One user is the counter, which then sees a divided count. The other is the watchdog tick path, which then produces a divided watchdog tick while the counter runs undivided. When the counter rolls over, it sets a sticky flag that only an explicit clear removes.

Software loads the counter through a write strobe. A load resets the divide chain when the chain belongs to the counter, and it blocks counting for the next two instruction ticks. A watchdog clear resets the chain when the chain belongs to the watchdog. The external pin is synchronized into the single clock domain, and each selected edge becomes a one-cycle count event. Nothing runs on a second clock.

Top module: `tmr8_shared_psc`

## Requirements
- R1: After reset the counter value is 00h and the overflow flag is 0.
- R2: When `mode_cfg[5]` is 0 the count source is `cyc_tick`. When `mode_cfg[3]` is 1 the counter then advances by exactly one for every counted `cyc_tick`.
- R3: A step from FFh to 00h sets `ovf_flag`. The flag stays set until `flag_clr` is pulsed, and a load does not clear it. If a rollover and `flag_clr` fall in the same cycle, the flag ends up set.
- R4: When `mode_cfg[5]` is 1 the count source is `ext_clk`, taken through a two-stage synchronizer. `mode_cfg[4]` = 0 counts rising edges and `mode_cfg[4]` = 1 counts falling edges, one count per edge.
- R5: When `mode_cfg[3]` is 0 the divide chain feeds the counter. The counter then advances once per 2^(r+1) source events, where r = `mode_cfg[2:0]`.
- R6: When `mode_cfg[3]` is 1 the chain feeds the watchdog, and `wdt_tick` pulses once per 2^r `wdt_raw` pulses. When `mode_cfg[3]` is 0, `wdt_tick` follows `wdt_raw` undivided.
- R7: A `wr_en` cycle loads `wr_data` into the counter, and the load wins over any increment in that same cycle. When `mode_cfg[3]` is 0 the load also resets the divide chain.
- R8: After a load, the next two `cyc_tick` cycles do not advance the counter or the divide chain.
- R9: When `mode_cfg[3]` is 1, a `wdt_clr` pulse resets the divide chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_clk | input | 1 | External count pin, asynchronous |
| mode_cfg | input | 6 | [5] source, [4] falling edge, [3] chain to watchdog, [2:0] rate |
| wr_en | input | 1 | Counter load strobe |
| wr_data | input | 8 | Counter load value |
| flag_clr | input | 1 | Clears the overflow flag |
| wdt_raw | input | 1 | Raw watchdog tick |
| wdt_clr | input | 1 | Watchdog clear strobe |
| tmr_q | output | 8 | Counter value |
| ovf_flag | output | 1 | Sticky rollover flag |
| wdt_tick | output | 1 | Watchdog tick after the divide chain |

## Verification
A divide-chain count that is off shows up as the counter advancing one tap early or late. That can be seen within 2^(r+1) source events of a load, so every rate is swept against a count worked out arithmetically. A stale chain after a load or a watchdog clear moves the first divided event earlier. An inhibit window that is too long or too short shifts the counter by one after exactly two ticks. The sticky flag is checked at its rollover cycle, at a cycle where a clear coincides with a rollover, and after a later load.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int RATE_W = 3;
  localparam int PSC_W  = 2 ** RATE_W;

  typedef struct packed {
    logic              src_ext;
    logic              fall_edge;
    logic              psc_to_wdt;
    logic [RATE_W-1:0] rate;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_evt
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    if (fall_sel) edge_evt = prev_q & ~sync_q[STAGES-1];
    else          edge_evt = ~prev_q & sync_q[STAGES-1];
  end
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              clr,
  input  logic              to_wdt,
  input  logic [RATE_W-1:0] rate,
  output logic              tap_pulse
);
  localparam int SH_W = RATE_W + 1;

  logic [PSC_W-1:0] cnt_q, cnt_d;
  logic [PSC_W-1:0] mask;
  logic [SH_W-1:0]  shift;

  // timer owner divides by 2^(rate+1), watchdog owner by 2^rate
  always_comb begin
    shift = {1'b0, rate} + (to_wdt ? SH_W'(0) : SH_W'(1));
    for (int i = 0; i < PSC_W; i++) mask[i] = (i < int'(shift));
  end

  always_comb begin
    tap_pulse = evt & ~clr & ((cnt_q & mask) == mask);
    if (clr)      cnt_d = '0;
    else if (evt) cnt_d = cnt_q + PSC_W'(1);
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
  parameter int TMR_W       = 8,
  parameter int INHIBIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             wr_en,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             inc,
  input  logic             flag_clr,
  output logic             count_ok,
  output logic [TMR_W-1:0] tmr_q,
  output logic             ovf_flag
);
  localparam int INH_W = $clog2(INHIBIT_CYC + 1);

  logic [INH_W-1:0] inh_q, inh_d;
  logic [TMR_W-1:0] tmr_d;
  logic             flag_d, wrap;

  assign count_ok = (inh_q == '0) & ~wr_en;

  always_comb begin
    if (wr_en)                     inh_d = INH_W'(INHIBIT_CYC);
    else if (cyc_tick && inh_q != '0) inh_d = inh_q - INH_W'(1);
    else                           inh_d = inh_q;
  end

  always_comb begin
    wrap = 1'b0;
    if (wr_en) begin
      tmr_d = wr_data;
    end else if (inc) begin
      tmr_d = tmr_q + TMR_W'(1);
      wrap  = (tmr_q == '1);
    end else begin
      tmr_d = tmr_q;
    end
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = ovf_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q    <= '0;
      tmr_q    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      inh_q    <= inh_d;
      tmr_q    <= tmr_d;
      ovf_flag <= flag_d;
    end
  end
endmodule

// File: rtl/tmr8_shared_psc.sv
module tmr8_shared_psc
  import tmr8_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             ext_clk,
  input  logic [5:0]       mode_cfg,
  input  logic             wr_en,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             flag_clr,
  input  logic             wdt_raw,
  input  logic             wdt_clr,
  output logic [TMR_W-1:0] tmr_q,
  output logic             ovf_flag,
  output logic             wdt_tick
);
  tmr_cfg_t cfg;
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       ext_evt, src_evt, count_ok, gated_evt;
  logic       psc_evt, psc_clr, psc_pulse, tmr_inc;

  assign cfg = tmr_cfg_t'(mode_cfg);

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pin      (ext_clk),
    .fall_sel (cfg.fall_edge),
    .edge_evt (ext_evt)
  );

  always_comb begin
    src_evt   = cfg.src_ext ? ext_evt : cyc_tick;
    gated_evt = src_evt & count_ok;
    psc_evt   = cfg.psc_to_wdt ? wdt_raw : gated_evt;
    psc_clr   = cfg.psc_to_wdt ? wdt_clr : wr_en;
    tmr_inc   = cfg.psc_to_wdt ? gated_evt : psc_pulse;
    wdt_tick  = cfg.psc_to_wdt ? psc_pulse : wdt_raw;
  end

  tmr8_prescaler u_psc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt       (psc_evt),
    .clr       (psc_clr),
    .to_wdt    (cfg.psc_to_wdt),
    .rate      (cfg.rate),
    .tap_pulse (psc_pulse)
  );

  tmr8_core #(.TMR_W(TMR_W), .INHIBIT_CYC(INHIBIT_CYC)) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cyc_tick (cyc_tick),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .inc      (tmr_inc),
    .flag_clr (flag_clr),
    .count_ok (count_ok),
    .tmr_q    (tmr_q),
    .ovf_flag (ovf_flag)
  );
endmodule

// File: rtl/tmr8_shared_psc_chk.sv
module tmr8_shared_psc_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [TMR_W-1:0] wr_data,
  input logic             flag_clr,
  input logic             wdt_raw,
  input logic [TMR_W-1:0] tmr_q,
  input logic             ovf_flag,
  input logic             wdt_tick
);
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R3

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_q) == '1 && tmr_q == '0 && !$past(wr_en)) |-> ovf_flag); // R3

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tmr_q == $past(wr_data))); // R7

  AST_POST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !wr_en) |=> $stable(tmr_q)); // R8

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (tmr_q == $past(tmr_q) || tmr_q == TMR_W'($past(tmr_q) + TMR_W'(1)))); // R2

  AST_WDT_FROM_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tick |-> wdt_raw); // R6
endmodule

bind tmr8_shared_psc tmr8_shared_psc_chk #(.TMR_W(TMR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .flag_clr (flag_clr),
  .wdt_raw  (wdt_raw),
  .tmr_q    (tmr_q),
  .ovf_flag (ovf_flag),
  .wdt_tick (wdt_tick)
);

// File: tb/tmr8_shared_psc_tb_top.sv
module tmr8_shared_psc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, cyc_tick, ext_clk, wr_en, flag_clr, wdt_raw, wdt_clr;
  logic [5:0] mode_cfg;
  logic [7:0] wr_data, tmr_q;
  logic       ovf_flag, wdt_tick;
  int checks = 0;
  int failures = 0;
  int pulses;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_shared_psc dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_clk(ext_clk),
    .mode_cfg(mode_cfg), .wr_en(wr_en), .wr_data(wr_data),
    .flag_clr(flag_clr), .wdt_raw(wdt_raw), .wdt_clr(wdt_clr),
    .tmr_q(tmr_q), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_tick = 1'b1;
    end
    @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_flag_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic pulse_wdt_clr();
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
  endtask

  task automatic raw_pulses(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wdt_raw = 1'b1;
      #1;
      if (wdt_tick) seen++;
    end
    @(negedge clk);
    wdt_raw = 1'b0;
  endtask

  task automatic ext_train(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; idle(4);
      ext_clk = 1'b0; idle(4);
    end
    ext_clk = 1'b1; idle(6);
  endtask

  initial begin
    idle(200000);
    failures++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_tick = 1'b0; ext_clk = 1'b0; wr_en = 1'b0;
    flag_clr = 1'b0; wdt_raw = 1'b0; wdt_clr = 1'b0;
    mode_cfg = 6'b001000; wr_data = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 tmr", int'(tmr_q), 0);
    check("R1 flag", int'(ovf_flag), 0);
    check("R1 wdt", int'(wdt_tick), 0);

    // R2 internal undivided, R8 inhibit
    mode_cfg = 6'b001000;
    load(8'h40);
    ticks(2);
    check("R8 two ticks blocked", int'(tmr_q), 8'h40);
    ticks(1);
    check("R8 third tick counts", int'(tmr_q), 8'h41);
    ticks(20);
    check("R2 undivided count", int'(tmr_q), 8'h41 + 20);

    // R7 load wins over tick in the same cycle
    @(negedge clk); cyc_tick = 1'b1; wr_en = 1'b1; wr_data = 8'h90;
    @(negedge clk); cyc_tick = 1'b0; wr_en = 1'b0;
    check("R7 load wins", int'(tmr_q), 8'h90);

    // R5 sweep of every timer ratio
    for (int r = 0; r < 8; r++) begin
      int dv;
      dv = 1 << (r + 1);
      mode_cfg = {3'b000, 3'(r)};
      load(8'h00);
      ticks(2 + 4 * dv - 1);
      check($sformatf("R5 rate%0d before tap", r), int'(tmr_q), 3);
      ticks(1);
      check($sformatf("R5 rate%0d at tap", r), int'(tmr_q), 4);
    end

    // R7 load clears the chain (divide by 4)
    mode_cfg = 6'b000001;
    load(8'h20);
    ticks(2 + 3);
    load(8'h20);
    ticks(2 + 3);
    check("R7 chain cleared by load", int'(tmr_q), 8'h20);
    ticks(1);
    check("R7 first tap after load", int'(tmr_q), 8'h21);

    // R3 rollover and sticky flag
    mode_cfg = 6'b001000;
    pulse_flag_clr();
    load(8'hFD);
    ticks(2 + 2);
    check("R3 at FF", int'(tmr_q), 8'hFF);
    check("R3 flag before wrap", int'(ovf_flag), 0);
    ticks(1);
    check("R3 wrap value", int'(tmr_q), 0);
    check("R3 flag set", int'(ovf_flag), 1);
    ticks(3);
    check("R3 flag sticky", int'(ovf_flag), 1);
    pulse_flag_clr();
    check("R3 flag cleared", int'(ovf_flag), 0);
    load(8'hFF);
    ticks(2);
    @(negedge clk); cyc_tick = 1'b1; flag_clr = 1'b1;
    @(negedge clk); cyc_tick = 1'b0; flag_clr = 1'b0;
    check("R3 set beats clear", int'(ovf_flag), 1);
    load(8'h55);
    check("R3 load keeps flag", int'(ovf_flag), 1);

    // R4 external edges
    cyc_tick = 1'b1;
    mode_cfg = 6'b101000;
    load(8'h00);
    idle(4);
    ext_train(5);
    check("R4 rising edges", int'(tmr_q), 6);
    ext_clk = 1'b0; idle(6);
    mode_cfg = 6'b111000;
    load(8'h00);
    idle(4);
    ext_train(5);
    check("R4 falling edges", int'(tmr_q), 5);
    ext_clk = 1'b0; idle(6);
    cyc_tick = 1'b0;

    // R6 watchdog divide sweep
    for (int r = 0; r < 8; r++) begin
      int dv;
      dv = 1 << r;
      mode_cfg = {3'b001, 3'(r)};
      pulse_wdt_clr();
      raw_pulses(3 * dv - 1, pulses);
      check($sformatf("R6 wdt rate%0d", r), pulses, 2);
    end

    // R9 watchdog clear resets chain
    for (int r = 1; r < 8; r++) begin
      int dv;
      dv = 1 << r;
      mode_cfg = {3'b001, 3'(r)};
      pulse_wdt_clr();
      raw_pulses(dv - 1, pulses);
      pulse_wdt_clr();
      raw_pulses(dv - 1, pulses);
      check($sformatf("R9 no early tick rate%0d", r), pulses, 0);
      raw_pulses(1, pulses);
      check($sformatf("R9 tick after clear rate%0d", r), pulses, 1);
    end

    // R6 chain with timer: watchdog undivided
    mode_cfg = 6'b000111;
    raw_pulses(5, pulses);
    check("R6 wdt undivided", pulses, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule